// File: doc/BRIEF.md
# Maskable Alarm Match and Interrupt Router

This block compares a running time-of-day and calendar against two programmed alarm settings each time the time advances by one second. The first alarm holds seconds, minutes, hours and a day-or-date value; the second holds minutes, hours and a day-or-date value. Each field carries a mask bit, so an alarm can repeat every second, every minute, every hour or every day, or fire only on a full match. A match sets a sticky flag that software clears by writing zero.

Two active-low interrupt outputs report the flags. Each alarm has an enable bit. A routing bit selects one of two schemes. In the first, each alarm drives its own pin. In the second, both alarms share pin A and pin B carries a square wave. The square wave is divided down from a 32.768 kHz reference input. The time counters sit outside this block and supply the current time together with a one-cycle update strobe.

Top module: `rtc_alarm_router`

## Requirements
- R1: After synchronous reset all alarm registers read 0x00. The control register reads 0x1C (rate code 11, routing 1, both enables 0). The flag register reads 0x00, and both interrupt outputs are high.
- R2: Register map: address 0 holds alarm-1 seconds, 1 alarm-1 minutes, 2 alarm-1 hours, 3 alarm-1 day/date, 4 alarm-2 minutes, 5 alarm-2 hours and 6 alarm-2 day/date, all full bytes. Address 7 is control: bit0 enable 1, bit1 enable 2, bit2 routing, bits 4:3 rate, upper bits read 0. Address 8 is flags: bit0 flag 1, bit1 flag 2. Every other address reads 0x00.
- R3: In each alarm register, bit 7 is the mask bit and bits 6:0 hold the BCD value; the day/date register uses bits 5:0 for the value. For alarm 1, the mask bits {day/date, hours, minutes, seconds} select the match: 1111 fires on every update, 1110 needs seconds, 1100 needs seconds and minutes, 1000 needs seconds, minutes and hours, and 0000 also needs day/date.
- R4: Any other alarm-1 mask pattern never sets flag 1, even when every field matches.
- R5: Alarm 2 fires only on an update whose seconds are 00. Its masks {day/date, hours, minutes} work as follows: 111 fires every minute, 110 needs minutes, 100 needs minutes and hours, and 000 also needs day/date. Any other pattern never fires.
- R6: Bit 6 of a day/date register set to 1 compares the value with the 3-bit day of week. Set to 0, it compares the 6-bit value with the date of month.
- R7: Matches are evaluated only in a cycle with the one-second strobe high. A flag, once set, stays set across later non-matching updates.
- R8: Writing the flag register clears each flag whose written bit is 0 and leaves each flag whose written bit is 1 unchanged. A match in the same cycle as a clearing write leaves the flag set.
- R9: With routing 1, int_a_n is low exactly while flag 1 and enable 1 are both set. int_b_n is low exactly while flag 2 and enable 2 are both set.
- R10: With routing 0, int_a_n is low while either flag is set together with its own enable, and int_b_n carries the square wave.
- R11: The rate code selects the square-wave period in reference cycles: 11 gives 1, 10 gives 4, 01 gives 8, and 00 gives 32768.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address for write and read |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| sec_tick | input | 1 | One-cycle strobe on each one-second time update |
| now_sec | input | 7 | Current seconds, BCD |
| now_min | input | 7 | Current minutes, BCD |
| now_hour | input | 7 | Current hours, including format and AM/PM bits |
| now_wday | input | 3 | Current day of week, 1 to 7 |
| now_mday | input | 6 | Current date of month, BCD |
| ref_in | input | 1 | 32.768 kHz reference, asynchronous to clk |
| int_a_n | output | 1 | Interrupt A, active low |
| int_b_n | output | 1 | Interrupt B (active low) or square wave |

## Verification
Each alarm-1 mask pattern is tried twice: once with exactly the fields it needs matching and once with one of those fields off by one. This separates a pattern that checks too few fields from one that checks too many. Alarm 2 is tried at seconds 00 and at a non-zero second, which shows whether it ignores its implied seconds condition. The day/date select is tried with date and weekday values that disagree, so a swapped select is caught. The square wave is checked by measuring its exact period at each rate code, and the routing is checked by toggling the enables while a flag stays set.

// File: rtl/rtc_alarm_pkg.sv
// Shared types and register addresses for the alarm router.
// Assumes an 8-bit register port with a 4-bit address.
package rtc_alarm_pkg;

    localparam int REG_AW     = 4;
    localparam int REG_DW     = 8;
    localparam int ALARM_REGS = 7;
    localparam int N_ALARMS   = 2;

    localparam logic [REG_AW-1:0] ADR_A1_SEC  = 4'd0;
    localparam logic [REG_AW-1:0] ADR_A1_MIN  = 4'd1;
    localparam logic [REG_AW-1:0] ADR_A1_HOUR = 4'd2;
    localparam logic [REG_AW-1:0] ADR_A1_DDAY = 4'd3;
    localparam logic [REG_AW-1:0] ADR_A2_MIN  = 4'd4;
    localparam logic [REG_AW-1:0] ADR_A2_HOUR = 4'd5;
    localparam logic [REG_AW-1:0] ADR_A2_DDAY = 4'd6;
    localparam logic [REG_AW-1:0] ADR_CTRL    = 4'd7;
    localparam logic [REG_AW-1:0] ADR_FLAGS   = 4'd8;

    // Control register content, LSB first: en1, en2, route, rate
    typedef struct packed {
        logic [1:0] rate;
        logic       route;
        logic       en2;
        logic       en1;
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '{rate: 2'b11, route: 1'b1, en2: 1'b0, en1: 1'b0};

    // Time field register: mask in bit 7, BCD value below
    typedef struct packed {
        logic       mask;
        logic [6:0] val;
    } tfield_t;

    // Day/date field register: mask, weekday select, value
    typedef struct packed {
        logic       mask;
        logic       by_wday;
        logic [5:0] val;
    } dfield_t;

    // Complete setting of one alarm as seen by a comparator
    typedef struct packed {
        tfield_t sec;
        tfield_t min;
        tfield_t hour;
        dfield_t dday;
    } alarm_cfg_t;

endpackage

// File: rtl/alarm_match.sv
// Combinational comparator for one alarm. Checks the current time against
// the alarm setting under the four mask bits. Only the five legal mask
// patterns can produce a hit. Assumes BCD inputs that are held stable
// while sec_tick is sampled.
module alarm_match
    import rtc_alarm_pkg::*;
(
    input  alarm_cfg_t cfg,
    input  logic [6:0] now_sec,
    input  logic [6:0] now_min,
    input  logic [6:0] now_hour,
    input  logic [2:0] now_wday,
    input  logic [5:0] now_mday,
    output logic       hit
);

    logic       sec_eq;
    logic       min_eq;
    logic       hour_eq;
    logic       dday_eq;
    logic [3:0] masks;

    // Per-field equality, with the day/date field picking its source
    always_comb begin
        sec_eq  = (cfg.sec.val  == now_sec);
        min_eq  = (cfg.min.val  == now_min);
        hour_eq = (cfg.hour.val == now_hour);
        if (cfg.dday.by_wday) begin
            dday_eq = (cfg.dday.val[2:0] == now_wday);
        end else begin
            dday_eq = (cfg.dday.val == now_mday);
        end
        masks = {cfg.dday.mask, cfg.hour.mask, cfg.min.mask, cfg.sec.mask};
    end

    // Legal mask patterns widen the compare step by step; others never hit
    always_comb begin
        unique case (masks)
            4'b1111: hit = 1'b1;
            4'b1110: hit = sec_eq;
            4'b1100: hit = sec_eq & min_eq;
            4'b1000: hit = sec_eq & min_eq & hour_eq;
            4'b0000: hit = sec_eq & min_eq & hour_eq & dday_eq;
            default: hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/alarm_regfile.sv
// Register file for the alarm settings, control and sticky flags.
// Flags are set on a strobed hit. A write of 0 clears a flag and a write
// of 1 leaves it alone; a hit in the same cycle wins over a clear.
// Assumes wr_en and addr are synchronous to clk.
module alarm_regfile
    import rtc_alarm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] addr,
    input  logic [REG_DW-1:0] wdata,
    input  logic              sec_tick,
    input  logic [N_ALARMS-1:0] hit,
    output logic [REG_DW-1:0] rdata,
    output logic [REG_DW-1:0] alarm_byte [ALARM_REGS],
    output ctrl_t             ctrl,
    output logic [N_ALARMS-1:0] flag
);

    localparam int CTRL_W = $bits(ctrl_t);

    logic                flag_wr;
    logic [N_ALARMS-1:0] keep_mask;

    assign flag_wr   = wr_en && (addr == ADR_FLAGS);
    assign keep_mask = flag_wr ? wdata[N_ALARMS-1:0] : {N_ALARMS{1'b1}};

    // Alarm setting bytes, one register per address
    generate
        for (genvar g = 0; g < ALARM_REGS; g++) begin : g_alarm_reg
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    alarm_byte[g] <= '0;
                end else if (wr_en && (addr == REG_AW'(g))) begin
                    alarm_byte[g] <= wdata;
                end
            end
        end
    endgenerate

    // Control register with its non-zero reset value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= CTRL_RESET;
        end else if (wr_en && (addr == ADR_CTRL)) begin
            ctrl <= ctrl_t'(wdata[CTRL_W-1:0]);
        end
    end

    // Sticky flags: set by a strobed hit, cleared only by a zero write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= '0;
        end else begin
            flag <= (flag & keep_mask) | (hit & {N_ALARMS{sec_tick}});
        end
    end

    // Read multiplexer
    always_comb begin
        rdata = '0;
        if (addr < REG_AW'(ALARM_REGS)) begin
            rdata = alarm_byte[addr[2:0]];
        end else if (addr == ADR_CTRL) begin
            rdata = REG_DW'(ctrl);
        end else if (addr == ADR_FLAGS) begin
            rdata = REG_DW'(flag);
        end
    end

    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        flag[0] && !(flag_wr && !wdata[0]) |=> flag[0]); // R7
    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        flag_wr && !wdata[1] && !(sec_tick && hit[1]) |=> !flag[1]); // R8
    AST_SET_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !flag[0] && !sec_tick |=> !flag[0]); // R7
    AST_HIT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick && hit[0] |=> flag[0]); // R8

endmodule

// File: rtl/sqw_divider.sv
// Square-wave source. Synchronises the 32.768 kHz reference into the clk
// domain, counts its rising edges and selects the reference or one
// counter bit as the output. Assumes clk is more than twice the
// reference frequency.
module sqw_divider #(
    parameter int DIV_W = 15
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_in,
    input  logic [1:0] rate,
    output logic       sqw
);

    localparam int TAP_FAST = 1;
    localparam int TAP_MID  = 2;
    localparam int TAP_SLOW = DIV_W - 1;

    logic [2:0]       ref_sync;
    logic             ref_rise;
    logic [DIV_W-1:0] cnt;

    // Two-stage synchroniser plus one stage for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_sync <= '0;
        end else begin
            ref_sync <= {ref_sync[1:0], ref_in};
        end
    end

    assign ref_rise = ref_sync[1] & ~ref_sync[2];

    // Count reference rising edges
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (ref_rise) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Rate select: reference, divide by 4, divide by 8, divide by 2^DIV_W
    always_comb begin
        unique case (rate)
            2'b11:   sqw = ref_sync[1];
            2'b10:   sqw = cnt[TAP_FAST];
            2'b01:   sqw = cnt[TAP_MID];
            default: sqw = cnt[TAP_SLOW];
        endcase
    end

    AST_DIV_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_rise |=> $stable(cnt)); // R11

endmodule

// File: rtl/rtc_alarm_router.sv
// Top of the alarm router: register file, two alarm comparators, square-wave
// divider and the interrupt steering. Assumes the time inputs are stable in
// the cycle where sec_tick is high. The second alarm has no seconds
// register; its seconds field is tied to a non-masked 00.
module rtc_alarm_router
    import rtc_alarm_pkg::*;
#(
    parameter int DIV_W = 15
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [3:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    input  logic       sec_tick,
    input  logic [6:0] now_sec,
    input  logic [6:0] now_min,
    input  logic [6:0] now_hour,
    input  logic [2:0] now_wday,
    input  logic [5:0] now_mday,
    input  logic       ref_in,
    output logic       int_a_n,
    output logic       int_b_n
);

    logic [REG_DW-1:0]   alarm_byte [ALARM_REGS];
    ctrl_t               ctrl;
    logic [N_ALARMS-1:0] flag;
    logic [N_ALARMS-1:0] hit;
    alarm_cfg_t          cfg [N_ALARMS];
    logic                sqw;
    logic                irq1;
    logic                irq2;

    // Alarm configurations taken from the register bytes
    always_comb begin
        cfg[0].sec  = tfield_t'(alarm_byte[ADR_A1_SEC[2:0]]);
        cfg[0].min  = tfield_t'(alarm_byte[ADR_A1_MIN[2:0]]);
        cfg[0].hour = tfield_t'(alarm_byte[ADR_A1_HOUR[2:0]]);
        cfg[0].dday = dfield_t'(alarm_byte[ADR_A1_DDAY[2:0]]);
        cfg[1].sec  = '{mask: 1'b0, val: 7'h00};
        cfg[1].min  = tfield_t'(alarm_byte[ADR_A2_MIN[2:0]]);
        cfg[1].hour = tfield_t'(alarm_byte[ADR_A2_HOUR[2:0]]);
        cfg[1].dday = dfield_t'(alarm_byte[ADR_A2_DDAY[2:0]]);
    end

    alarm_regfile i_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .addr       (addr),
        .wdata      (wdata),
        .sec_tick   (sec_tick),
        .hit        (hit),
        .rdata      (rdata),
        .alarm_byte (alarm_byte),
        .ctrl       (ctrl),
        .flag       (flag)
    );

    generate
        for (genvar g = 0; g < N_ALARMS; g++) begin : g_match
            alarm_match i_match (
                .cfg      (cfg[g]),
                .now_sec  (now_sec),
                .now_min  (now_min),
                .now_hour (now_hour),
                .now_wday (now_wday),
                .now_mday (now_mday),
                .hit      (hit[g])
            );
        end
    endgenerate

    sqw_divider #(.DIV_W(DIV_W)) i_sqw (
        .clk    (clk),
        .rst_n  (rst_n),
        .ref_in (ref_in),
        .rate   (ctrl.rate),
        .sqw    (sqw)
    );

    // Interrupt steering: separate pins, or shared pin A plus square wave on B
    always_comb begin
        irq1 = flag[0] & ctrl.en1;
        irq2 = flag[1] & ctrl.en2;
        if (ctrl.route) begin
            int_a_n = ~irq1;
            int_b_n = ~irq2;
        end else begin
            int_a_n = ~(irq1 | irq2);
            int_b_n = sqw;
        end
    end

    AST_A2_AT_ZERO_SEC: assert property (@(posedge clk) disable iff (!rst_n)
        hit[1] |-> (now_sec == 7'h00)); // R5
    AST_BAD_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ({cfg[0].dday.mask, cfg[0].hour.mask, cfg[0].min.mask, cfg[0].sec.mask} == 4'b0100)
        |-> !hit[0]); // R4
    AST_INTA_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        !int_a_n |-> (flag != '0)); // R9
    AST_INTB_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.route && !flag[1] |-> int_b_n); // R9

endmodule

// File: tb/test_rtc_alarm_router.sv
// Directed bench for the alarm router, one task per scenario.
module test_rtc_alarm_router;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       sec_tick = 1'b0;
    logic [6:0] now_sec = '0;
    logic [6:0] now_min = '0;
    logic [6:0] now_hour = '0;
    logic [2:0] now_wday = 3'd1;
    logic [5:0] now_mday = 6'h01;
    logic       ref_in = 1'b0;
    logic       int_a_n;
    logic       int_b_n;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    rtc_alarm_router i_rtc_alarm_router (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .sec_tick(sec_tick), .now_sec(now_sec), .now_min(now_min),
        .now_hour(now_hour), .now_wday(now_wday), .now_mday(now_mday),
        .ref_in(ref_in), .int_a_n(int_a_n), .int_b_n(int_b_n)
    );

    always #4 clk = ~clk;
    always @(negedge clk) ref_in <= ~ref_in;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic set_time(input logic [6:0] s, input logic [6:0] mi, input logic [6:0] h,
                            input logic [2:0] wd, input logic [5:0] md);
        now_sec = s; now_min = mi; now_hour = h; now_wday = wd; now_mday = md;
    endtask

    task automatic tick();
        @(negedge clk);
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
    endtask

    // Ctrl bits: en1 bit0, en2 bit1, route bit2, rate bits 4:3
    task automatic set_ctrl(input logic en1, input logic en2, input logic route, input logic [1:0] rate);
        wr(4'd7, {3'b000, rate, route, en2, en1});
    endtask

    // Period of int_b_n between two rising edges, in clk cycles
    task automatic measure(output int period);
        logic prev;
        int n;
        period = -1;
        prev = int_b_n;
        n = 0;
        while (n < 140000) begin
            @(negedge clk);
            n++;
            if (!prev && int_b_n) break;
            prev = int_b_n;
        end
        prev = int_b_n;
        period = 0;
        while (period < 140000) begin
            @(negedge clk);
            period++;
            if (!prev && int_b_n) break;
            prev = int_b_n;
        end
    endtask

    task automatic a1_try(input logic [3:0] m, input logic [6:0] s, input logic [6:0] mi,
                          input logic [6:0] h, input logic [5:0] md, input logic exp, input string tag);
        logic [7:0] d;
        wr(4'd0, {m[0], 7'h30});
        wr(4'd1, {m[1], 7'h15});
        wr(4'd2, {m[2], 7'h08});
        wr(4'd3, {m[3], 1'b0, 6'h12});
        wr(4'd8, 8'h00);
        set_time(s, mi, h, 3'd1, md);
        tick();
        rd(4'd8, d);
        chk(tag, d[0], exp);
    endtask

    task automatic a2_try(input logic [2:0] m, input logic dysel, input logic [6:0] s,
                          input logic [6:0] mi, input logic [2:0] wd, input logic [5:0] md,
                          input logic exp, input string tag);
        logic [7:0] d;
        wr(4'd4, {m[0], 7'h15});
        wr(4'd5, {m[1], 7'h08});
        wr(4'd6, {m[2], dysel, dysel ? 6'h03 : 6'h12});
        wr(4'd8, 8'h00);
        set_time(s, mi, 7'h08, wd, md);
        tick();
        rd(4'd8, d);
        chk(tag, d[1], exp);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        for (int a = 0; a < 7; a++) begin
            rd(4'(a), d);
            chk("R1 alarm reg reset", d, 8'h00);
        end
        rd(4'd7, d); chk("R1 ctrl reset", d, 8'h1C);
        rd(4'd8, d); chk("R1 flags reset", d, 8'h00);
        chk("R1 int_a_n reset", int_a_n, 1'b1);
        chk("R1 int_b_n reset", int_b_n, 1'b1);
    endtask

    task automatic t_regs();
        logic [7:0] d;
        for (int a = 0; a < 7; a++) wr(4'(a), 8'hA5 ^ 8'(a));
        for (int a = 0; a < 7; a++) begin
            rd(4'(a), d);
            chk("R2 alarm readback", d, 8'hA5 ^ 8'(a));
        end
        wr(4'd7, 8'hFF); rd(4'd7, d); chk("R2 ctrl upper bits zero", d, 8'h1F);
        wr(4'd9, 8'hFF); rd(4'd9, d); chk("R2 unused address", d, 8'h00);
        rd(4'd15, d); chk("R2 top address", d, 8'h00);
        set_ctrl(1'b0, 1'b0, 1'b1, 2'b11);
    endtask

    task automatic t_alarm1();
        a1_try(4'b1111, 7'h02, 7'h44, 7'h11, 6'h05, 1'b1, "R3 every second");
        a1_try(4'b1110, 7'h30, 7'h44, 7'h11, 6'h05, 1'b1, "R3 seconds match");
        a1_try(4'b1110, 7'h31, 7'h15, 7'h08, 6'h12, 1'b0, "R3 seconds miss");
        a1_try(4'b1100, 7'h30, 7'h15, 7'h11, 6'h05, 1'b1, "R3 min+sec match");
        a1_try(4'b1100, 7'h30, 7'h16, 7'h08, 6'h12, 1'b0, "R3 min+sec miss");
        a1_try(4'b1000, 7'h30, 7'h15, 7'h08, 6'h05, 1'b1, "R3 hour match");
        a1_try(4'b1000, 7'h30, 7'h15, 7'h09, 6'h12, 1'b0, "R3 hour miss");
        a1_try(4'b0000, 7'h30, 7'h15, 7'h08, 6'h12, 1'b1, "R3 full match");
        a1_try(4'b0000, 7'h30, 7'h15, 7'h08, 6'h13, 1'b0, "R3 full date miss");
        a1_try(4'b0100, 7'h30, 7'h15, 7'h08, 6'h12, 1'b0, "R4 bad pattern 0100");
        a1_try(4'b1010, 7'h30, 7'h15, 7'h08, 6'h12, 1'b0, "R4 bad pattern 1010");
        a1_try(4'b0111, 7'h30, 7'h15, 7'h08, 6'h12, 1'b0, "R4 bad pattern 0111");
    endtask

    task automatic t_alarm2();
        a2_try(3'b111, 1'b0, 7'h00, 7'h44, 3'd1, 6'h01, 1'b1, "R5 every minute at 00");
        a2_try(3'b111, 1'b0, 7'h05, 7'h44, 3'd1, 6'h01, 1'b0, "R5 not at seconds 05");
        a2_try(3'b110, 1'b0, 7'h00, 7'h15, 3'd1, 6'h01, 1'b1, "R5 minutes match");
        a2_try(3'b110, 1'b0, 7'h07, 7'h15, 3'd1, 6'h01, 1'b0, "R5 minutes match sec 07");
        a2_try(3'b100, 1'b0, 7'h00, 7'h15, 3'd1, 6'h01, 1'b1, "R5 hour+min match");
        a2_try(3'b000, 1'b0, 7'h00, 7'h15, 3'd1, 6'h12, 1'b1, "R5 full date match");
        a2_try(3'b011, 1'b0, 7'h00, 7'h15, 3'd1, 6'h12, 1'b0, "R5 bad pattern");
    endtask

    task automatic t_dysel();
        logic [7:0] d;
        // weekday select: value 3 vs weekday, date disagrees
        a2_try(3'b000, 1'b1, 7'h00, 7'h15, 3'd3, 6'h12, 1'b1, "R6 weekday match");
        a2_try(3'b000, 1'b1, 7'h00, 7'h15, 3'd4, 6'h03, 1'b0, "R6 weekday miss");
        // alarm 1 with weekday select: value 0x12 low bits = 2
        wr(4'd0, 8'h30); wr(4'd1, 8'h15); wr(4'd2, 8'h08);
        wr(4'd3, {1'b0, 1'b1, 6'h02});
        wr(4'd8, 8'h00);
        set_time(7'h30, 7'h15, 7'h08, 3'd2, 6'h09);
        tick();
        rd(4'd8, d);
        chk("R6 alarm1 weekday", d[0], 1'b1);
    endtask

    task automatic t_tick_sticky();
        logic [7:0] d;
        wr(4'd0, 8'hB0); wr(4'd1, 8'h95); wr(4'd2, 8'h88); wr(4'd3, 8'h92);
        wr(4'd8, 8'h00);
        for (int i = 0; i < 5; i++) @(negedge clk);
        rd(4'd8, d); chk("R7 no flag without tick", d[0], 1'b0);
        tick();
        rd(4'd8, d); chk("R7 flag on tick", d[0], 1'b1);
        wr(4'd0, 8'h30);
        set_time(7'h31, 7'h00, 7'h00, 3'd1, 6'h01);
        tick(); tick();
        rd(4'd8, d); chk("R7 flag sticky", d[0], 1'b1);
    endtask

    task automatic t_clear();
        logic [7:0] d;
        wr(4'd0, 8'hB0); wr(4'd1, 8'h95); wr(4'd2, 8'h88); wr(4'd3, 8'h92);
        wr(4'd4, 8'h95); wr(4'd5, 8'h88); wr(4'd6, 8'h92);
        set_time(7'h00, 7'h00, 7'h00, 3'd1, 6'h01);
        tick();
        rd(4'd8, d); chk("R8 both set", d, 8'h03);
        wr(4'd8, 8'h02);
        rd(4'd8, d); chk("R8 clear flag1 keep flag2", d, 8'h02);
        wr(4'd8, 8'h03);
        rd(4'd8, d); chk("R8 write ones no change", d, 8'h02);
        wr(4'd8, 8'h00);
        rd(4'd8, d); chk("R8 clear all", d, 8'h00);
        @(negedge clk);
        sec_tick = 1'b1; wr_en = 1'b1; addr = 4'd8; wdata = 8'h00;
        @(negedge clk);
        sec_tick = 1'b0; wr_en = 1'b0;
        rd(4'd8, d); chk("R8 set beats clear", d, 8'h03);
        wr(4'd8, 8'h00);
    endtask

    task automatic t_route_sep();
        set_ctrl(1'b1, 1'b1, 1'b1, 2'b11);
        wr(4'd0, 8'hB0); wr(4'd1, 8'h95); wr(4'd2, 8'h88); wr(4'd3, 8'h92);
        wr(4'd4, 8'h15);
        set_time(7'h05, 7'h00, 7'h00, 3'd1, 6'h01);
        tick();
        chk("R9 int_a low on flag1", int_a_n, 1'b0);
        chk("R9 int_b high no flag2", int_b_n, 1'b1);
        set_ctrl(1'b0, 1'b1, 1'b1, 2'b11);
        chk("R9 int_a released by enable", int_a_n, 1'b1);
        wr(4'd4, 8'h95);
        set_time(7'h00, 7'h00, 7'h00, 3'd1, 6'h01);
        tick();
        chk("R9 int_b low on flag2", int_b_n, 1'b0);
        chk("R9 int_a stays high", int_a_n, 1'b1);
        wr(4'd8, 8'h01);
        chk("R9 int_b released by clear", int_b_n, 1'b1);
        wr(4'd8, 8'h00);
    endtask

    task automatic t_route_shared();
        int p;
        wr(4'd0, 8'h30);
        set_ctrl(1'b0, 1'b1, 1'b0, 2'b11);
        set_time(7'h00, 7'h00, 7'h00, 3'd1, 6'h01);
        tick();
        chk("R10 int_a low from alarm2", int_a_n, 1'b0);
        measure(p);
        chk("R10 int_b carries square wave", p, 2);
        set_ctrl(1'b0, 1'b0, 1'b0, 2'b11);
        chk("R10 int_a released", int_a_n, 1'b1);
        wr(4'd8, 8'h00);
    endtask

    task automatic t_rates();
        int p;
        set_ctrl(1'b0, 1'b0, 1'b0, 2'b10);
        measure(p); chk("R11 rate 10 period", p, 8);
        set_ctrl(1'b0, 1'b0, 1'b0, 2'b01);
        measure(p); chk("R11 rate 01 period", p, 16);
        set_ctrl(1'b0, 1'b0, 1'b0, 2'b00);
        measure(p); chk("R11 rate 00 period", p, 65536);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_alarm1();
        t_alarm2();
        t_dysel();
        t_tick_sticky();
        t_clear();
        t_route_sep();
        t_route_shared();
        t_rates();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule